// File: doc/BRIEF.md
# Character-Based Raster Timing Generator

This block runs the raster of a display controller from the packed timing fields that a register block holds. Horizontal values are kept in character units of eight pixels, each with its own fixed offset. Vertical counts are ten bits wide, and their two upper bits sit in a separate overflow register. The block decodes these fields into plain counts and then steps a pixel column counter and a line counter. From the two counters it derives horizontal sync, vertical sync and a display-enable window.

Register values may change at any time. The block copies the decoded timing into a shadow set only on the last pixel of a frame, and also while reset is held. The frame being scanned therefore always keeps one consistent geometry. Both sync outputs are active high and the raster is progressive.

Top module: `crtc_raster_gen`

## Requirements
- R1: The line length in characters is formed from two sources. Bits 5:0 come from (htot_reg + 5) and bits 7:6 from ext_reg[5:4]. pix_x counts 0 up to 8 × that length − 1 and then returns to 0.
- R2: The frame height in lines is {ovf_reg[5], ovf_reg[0], vtot_reg} + 2. line_y advances by one only on the cycle after pix_x wraps, and returns to 0 after the last line.
- R3: disp_en is high exactly when pix_x < 8 × (hdisp_reg + 1) and line_y < {ovf_reg[6], ovf_reg[1], vde_reg} + 1.
- R4: hsync is high exactly when the character index pix_x / 8 is at least hss_reg − 1 and below hse_reg − 1. No pulse appears when hse_reg ≤ hss_reg, and the pulse always rises on a character boundary.
- R5: Call the displayed line count VD. The line numbered VD is a single front-porch line. vsync is high for the two lines numbered VD+1 and VD+2 and never overlaps disp_en.
- R6: A register change made during a frame has no effect until the frame ends. Register values present on the final pixel of a frame govern the whole next frame.
- R7: While rst_n is low at a clock edge, pix_x and line_y are 0 and the shadow timing is loaded from the current registers. The first cycle after release shows pixel 0 of line 0.
- R8: ext_reg[7:6] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| htot_reg | input | 8 | Line length in characters minus 5 |
| hdisp_reg | input | 8 | Displayed characters minus 1 |
| hss_reg | input | 8 | Horizontal sync start character plus 1 |
| hse_reg | input | 8 | Horizontal sync end character plus 1 |
| vtot_reg | input | 8 | Low 8 bits of frame line count minus 2 |
| vde_reg | input | 8 | Low 8 bits of displayed line count minus 1 |
| ovf_reg | input | 8 | Vertical high bits: [0] total b8, [1] display b8, [5] total b9, [6] display b9 |
| ext_reg | input | 8 | [5:4] line length bits 7:6; [7:6] ignored |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Active-picture window |
| pix_x | output | 12 | Current pixel column |
| line_y | output | 11 | Current line |

## Verification
Two events coincide on the last pixel of a frame. On that same clock edge the line counter wraps and the shadow timing reloads. The bench provokes this by writing a new geometry in the middle of a frame. It then compares every cycle against a model that adopts the new fields only at its own frame wrap, so a reload taken one cycle early or late, or mid-frame, shows up as a mismatch in column, line or one of the windows. The same collision happens with hsync when a sync window starts at character 0 and the shadow reload creates its rising edge, and the character-alignment property covers that case.

// File: rtl/crtc_pkg.sv
// Shared widths and the decoded timing record for the raster generator.
// Assumes characters are a power-of-two number of pixels wide.
package crtc_pkg;
    localparam int REG_W     = 8;               // width of each timing register
    localparam int PIX_SH    = 3;               // log2 of pixels per character
    localparam int HCH_W     = REG_W + 1;       // decoded character counts
    localparam int PX_W      = HCH_W + PIX_SH;  // pixel column counter
    localparam int VHI_W     = 2;               // vertical bits held outside the base register
    localparam int VLN_W     = REG_W + VHI_W + 1; // decoded line counts, one spare bit
    localparam int HTOT_BIAS = 5;
    localparam int HDSP_BIAS = 1;
    localparam int HSYN_BIAS = 1;
    localparam int VTOT_BIAS = 2;
    localparam int VDSP_BIAS = 1;
    localparam int FRONT_PORCH_LINES = 1;
    localparam int VSYNC_LINES       = 2;
    localparam int HTOT_LO_W = 6;               // low bits of total taken from the biased sum

    typedef struct packed {
        logic [HCH_W-1:0] h_total;   // characters per line
        logic [HCH_W-1:0] h_disp;    // displayed characters
        logic [HCH_W-1:0] h_ss;      // first sync character
        logic [HCH_W-1:0] h_se;      // first character after sync
        logic [VLN_W-1:0] v_total;   // lines per frame
        logic [VLN_W-1:0] v_disp;    // displayed lines
        logic [VLN_W-1:0] v_ss;      // first vsync line
        logic [VLN_W-1:0] v_se;      // first line after vsync
    } crtc_timing_t;
endpackage

// File: rtl/crtc_field_decode.sv
// Removes the register biases and gathers the scattered high bits into
// plain counts. Purely combinational; assumes the register block holds
// its values steady between writes.
module crtc_field_decode
    import crtc_pkg::*;
(
    input  logic [REG_W-1:0] htot_reg,
    input  logic [REG_W-1:0] hdisp_reg,
    input  logic [REG_W-1:0] hss_reg,
    input  logic [REG_W-1:0] hse_reg,
    input  logic [REG_W-1:0] vtot_reg,
    input  logic [REG_W-1:0] vde_reg,
    input  logic [REG_W-1:0] ovf_reg,
    input  logic [REG_W-1:0] ext_reg,
    output crtc_timing_t     timing
);
    logic [REG_W-1:0] htot_sum;
    logic [VLN_W-1:0] vt_raw;
    logic [VLN_W-1:0] vd_raw;

    // Decode horizontal fields: line length is stitched from biased sum and extension bits.
    always_comb begin
        htot_sum       = htot_reg + REG_W'(HTOT_BIAS);
        timing.h_total = {1'b0, ext_reg[5:4], htot_sum[HTOT_LO_W-1:0]};
        timing.h_disp  = {1'b0, hdisp_reg} + HCH_W'(HDSP_BIAS);
        timing.h_ss    = {1'b0, hss_reg} - HCH_W'(HSYN_BIAS);
        timing.h_se    = {1'b0, hse_reg} - HCH_W'(HSYN_BIAS);
    end

    // Decode vertical fields: high bits come from the overflow register only.
    always_comb begin
        vt_raw         = {1'b0, ovf_reg[5], ovf_reg[0], vtot_reg};
        vd_raw         = {1'b0, ovf_reg[6], ovf_reg[1], vde_reg};
        timing.v_total = vt_raw + VLN_W'(VTOT_BIAS);
        timing.v_disp  = vd_raw + VLN_W'(VDSP_BIAS);
        timing.v_ss    = timing.v_disp + VLN_W'(FRONT_PORCH_LINES);
        timing.v_se    = timing.v_ss + VLN_W'(VSYNC_LINES);
    end
endmodule

// File: rtl/crtc_timing_shadow.sv
// Holds the timing used by the frame in progress. Loads during reset and
// on the final pixel of a frame; otherwise holds.
module crtc_timing_shadow
    import crtc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  crtc_timing_t next_timing,
    output crtc_timing_t cur_timing
);
    // Capture decoded timing at reset or frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cur_timing <= next_timing;
        end
    end

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_timing));
endmodule

// File: rtl/crtc_raster_counter.sv
// Pixel column and line counters. Assumes totals are non-zero; uses
// greater-or-equal wrap tests so an out-of-range state still recovers.
module crtc_raster_counter
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  crtc_timing_t     timing,
    output logic [PX_W-1:0]  col,
    output logic [VLN_W-1:0] row,
    output logic             frame_end
);
    logic [PX_W-1:0] line_px;
    logic            line_end;

    // Last-pixel and last-line detection against the shadow timing.
    always_comb begin
        line_px   = {timing.h_total, {PIX_SH{1'b0}}};
        line_end  = (col >= line_px - PX_W'(1));
        frame_end = line_end && (row >= timing.v_total - VLN_W'(1));
    end

    // Advance the column every clock and the line at each column wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (line_end) begin
            col <= '0;
            row <= frame_end ? '0 : row + VLN_W'(1);
        end else begin
            col <= col + PX_W'(1);
        end
    end

    // R1
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col < line_px);
    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(row));
endmodule

// File: rtl/crtc_sync_gen.sv
// Derives sync pulses and the display window from the counters and the
// shadow timing. Combinational outputs; character index is column / 8.
module crtc_sync_gen
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  crtc_timing_t     timing,
    input  logic [PX_W-1:0]  col,
    input  logic [VLN_W-1:0] row,
    output logic             hsync,
    output logic             vsync,
    output logic             disp_en
);
    logic [HCH_W-1:0] chr;

    // Window compares in character units horizontally and lines vertically.
    always_comb begin
        chr     = col[PX_W-1:PIX_SH];
        hsync   = (chr >= timing.h_ss) && (chr < timing.h_se);
        vsync   = (row >= timing.v_ss) && (row < timing.v_se);
        disp_en = (chr < timing.h_disp) && (row < timing.v_disp);
    end

    // R4
    hsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> (col[PIX_SH-1:0] == '0));
    // R5
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> !vsync);
endmodule

// File: rtl/crtc_raster_gen.sv
// Top of the raster timing generator: decode, shadow, count, window.
// Assumes register inputs are synchronous to clk.
module crtc_raster_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  htot_reg,
    input  logic [REG_W-1:0]  hdisp_reg,
    input  logic [REG_W-1:0]  hss_reg,
    input  logic [REG_W-1:0]  hse_reg,
    input  logic [REG_W-1:0]  vtot_reg,
    input  logic [REG_W-1:0]  vde_reg,
    input  logic [REG_W-1:0]  ovf_reg,
    input  logic [REG_W-1:0]  ext_reg,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic [PX_W-1:0]   pix_x,
    output logic [VLN_W-1:0]  line_y
);
    crtc_timing_t decoded;
    crtc_timing_t active;
    logic         frame_end;

    crtc_field_decode u_decode (
        .htot_reg (htot_reg),  .hdisp_reg(hdisp_reg),
        .hss_reg  (hss_reg),   .hse_reg  (hse_reg),
        .vtot_reg (vtot_reg),  .vde_reg  (vde_reg),
        .ovf_reg  (ovf_reg),   .ext_reg  (ext_reg),
        .timing   (decoded)
    );

    crtc_timing_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .next_timing(decoded), .cur_timing(active)
    );

    crtc_raster_counter u_count (
        .clk(clk), .rst_n(rst_n), .timing(active),
        .col(pix_x), .row(line_y), .frame_end(frame_end)
    );

    crtc_sync_gen u_sync (
        .clk(clk), .rst_n(rst_n), .timing(active),
        .col(pix_x), .row(line_y),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en)
    );
endmodule

// File: tb/test_crtc_raster_gen.sv
module test_crtc_raster_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  htot, hdisp, hss, hse, vtot, vde, ovf, ext;
    logic        hsync, vsync, disp_en;
    logic [11:0] pix_x;
    logic [10:0] line_y;
    int checks = 0, failures = 0;
    int m_ht, m_hd, m_hs, m_he, m_vt, m_vd, ex, ey;
    bit done = 0;

    always #5 clk = ~clk;

    crtc_raster_gen i_crtc_raster_gen (
        .clk(clk), .rst_n(rst_n),
        .htot_reg(htot), .hdisp_reg(hdisp), .hss_reg(hss), .hse_reg(hse),
        .vtot_reg(vtot), .vde_reg(vde), .ovf_reg(ovf), .ext_reg(ext),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .pix_x(pix_x), .line_y(line_y)
    );

    // {htot, hdisp, hss, hse, vtot, vde, ovf, ext}
    localparam logic [63:0] CFG [8] = '{
        64'h05_05_08_0A_0A_07_00_00,  // base geometry
        64'h08_03_06_07_04_02_00_00,  // one-character hsync
        64'h06_02_05_05_06_03_00_00,  // empty hsync window
        64'h3B_20_30_38_02_01_00_10,  // line length bits 7:6 from ext
        64'h00_00_02_03_02_00_01_00,  // total bit 8
        64'h00_02_03_04_00_00_22_00,  // total bit 9, display bit 8
        64'h00_02_03_04_00_00_61_00,  // total bits 9:8, display bit 9
        64'h05_05_08_0A_0A_07_00_C0   // ext[7:6] set, must not matter
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, ex, ey);
        end
    endtask

    task automatic set_cfg(logic [63:0] c);
        {htot, hdisp, hss, hse, vtot, vde, ovf, ext} = c;
    endtask

    // Model of the decode rules, applied to the live register values.
    task automatic latch_model();
        m_ht = ((int'(htot) + 5) % 64) + 64 * int'(ext[5:4]);
        m_hd = int'(hdisp) + 1;
        m_hs = int'(hss) - 1;
        m_he = int'(hse) - 1;
        m_vt = int'(vtot) + 256 * int'(ovf[0]) + 512 * int'(ovf[5]) + 2;
        m_vd = int'(vde) + 256 * int'(ovf[1]) + 512 * int'(ovf[6]) + 1;
    endtask

    task automatic check_now(string ctx);
        chk({ctx, " R1 pix_x"}, int'(pix_x), ex);
        chk({ctx, " R2 line_y"}, int'(line_y), ey);
        chk({ctx, " R3 disp_en"}, int'(disp_en), int'((ex < m_hd * 8) && (ey < m_vd)));
        chk({ctx, " R4 hsync"}, int'(hsync), int'((ex / 8 >= m_hs) && (ex / 8 < m_he)));
        chk({ctx, " R5 vsync"}, int'(vsync), int'((ey >= m_vd + 1) && (ey <= m_vd + 2)));
    endtask

    task automatic run(int n, string ctx);
        for (int i = 0; i < n; i++) begin
            check_now(ctx);
            if (ex == m_ht * 8 - 1) begin
                ex = 0;
                if (ey == m_vt - 1) begin
                    ey = 0;
                    latch_model();
                end else ey++;
            end else ex++;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ex = 0; ey = 0;
        chk("R7 reset pix_x", int'(pix_x), 0);
        chk("R7 reset line_y", int'(line_y), 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        latch_model();
        ex = 0; ey = 0;
    endtask

    initial begin
        set_cfg(CFG[0]);
        @(negedge clk);
        do_reset();
        check_now("R7 first cycle");
        for (int k = 0; k < 8; k++) begin
            set_cfg(CFG[k]);
            do_reset();
            latch_model();
            run(m_ht * 8 * m_vt + 50, k == 7 ? "R8 ext-ignore" : "cfg");
        end
        // R6: rewrite geometry mid-frame; model adopts it only at its frame wrap
        set_cfg(CFG[0]);
        do_reset();
        run(400, "R6 pre");
        set_cfg(CFG[1]);
        run(960 - 400 + 624 + 30, "R6 switch");
        // R6: change lands exactly on the last pixel of a frame
        run(624 - 31, "R6 align");
        set_cfg(CFG[0]);
        run(960 + 20, "R6 edge");
        // R7: reset mid-line returns to origin
        do_reset();
        run(10, "R7 post");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule